// File: doc/BRIEF.md
# Dual-Mode Display Serial Command Receiver

This block is the receive side of a write-only serial link into a display controller. A host drives a serial clock, a data line, an active-low select and, in one framing, a separate command/data tag line. The block turns this stream into whole bytes. Each byte appears on a parallel output with a flag that tells display data from a command, and a strobe one system clock long marks it. A later stage decodes the commands; this block does not.

A static strap picks the framing. Strap low gives the 4-wire framing: each byte is 8 bits and the external tag line gives its type. Strap high gives the 3-wire framing: each frame is 9 bits and its leading bit is the tag. All serial pins pass through synchronisers into the system clock, which must run at least four times as fast as the serial clock. Edges are found on the synchronised copies. Releasing the select in the middle of a frame discards the partial frame and realigns the receiver to the next one.

Top module: `disp_serial_rx`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_byte` is 0x00 and `rx_is_data` is 0.
- R2: With `mode_3w` = 0, eight rising edges of `ser_clk` while `ser_csn` is low form one byte. The first bit sampled becomes bit 7 of `rx_byte` and the last becomes bit 0.
- R3: With `mode_3w` = 0, `rx_is_data` equals the level of `ser_dc` at the rising edge that samples bit 0 (1 = display data, 0 = command). Its level at earlier edges of the byte has no effect.
- R4: With `mode_3w` = 1, a frame is nine rising edges. The first bit sampled gives `rx_is_data` (1 = data, 0 = command), the next eight give `rx_byte` from bit 7 down to bit 0, and `ser_dc` is ignored.
- R5: Rising edges of `ser_clk` while `ser_csn` is high produce no strobe and do not shift the alignment of the next frame.
- R6: If `ser_csn` goes high before a frame is complete, that frame produces no strobe, and the next frame after reselection is received whole and correct.
- R7: Each completed frame raises `rx_valid` for exactly one system clock, with `rx_byte` and `rx_is_data` valid in that cycle.
- R8: Frames sent back to back within one select window each produce their own strobe, in order, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_3w | input | 1 | Static framing strap: 0 = 8-bit frames with external tag, 1 = 9-bit frames with in-band tag |
| ser_clk | input | 1 | Host serial clock; data is sampled on its rising edge |
| ser_sda | input | 1 | Host serial data, most significant bit first |
| ser_csn | input | 1 | Active-low select |
| ser_dc | input | 1 | External tag line, used with the 8-bit framing only |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | 1 = display data, 0 = command |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |

## Verification
A rising serial clock edge reaches the framer after two synchroniser stages and one edge-detect register. The strobe for a frame's final edge therefore appears in the third system clock after the edge is first sampled, well before the next serial edge. The scoreboard does not wait a fixed number of cycles. A driver task pushes the expected byte and tag when it sends a complete frame. A monitor that samples on the falling system clock edge pops and compares the entry whenever the strobe is high, and it also checks that the strobe was low in the previous cycle. A discarded or ignored frame pushes nothing, so any strobe it caused, or any entry left in the queue at the end, is reported.

// File: rtl/disp_srx_pkg.sv
package disp_srx_pkg;
   typedef enum logic {
      TAG_CMD  = 1'b0,
      TAG_DATA = 1'b1
   } tag_e;

   function automatic int unsigned frame_bits(input logic in_band, input int unsigned w);
      return in_band ? w + 1 : w;
   endfunction
endpackage

// File: rtl/srx_sync_bank.sv
module srx_sync_bank #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync_bank: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d_async[i]};
      end
      assign q_sync[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import disp_srx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_3w,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              csn_s,
   input  logic              dc_s,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_is_data,
   output logic              rx_valid
);
   localparam int unsigned MAX_BITS = DATA_W + 1;
   localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("srx_framer: DATA_W must be at least 2");
   end

   logic              scl_d;
   logic              rise;
   logic [CNT_W-1:0]  bit_cnt;
   logic [CNT_W-1:0]  last_idx;
   logic [DATA_W-1:0] shreg;
   logic              tag_q;
   logic              is_tag_bit;

   assign last_idx   = CNT_W'(frame_bits(mode_3w, DATA_W) - 1);
   assign rise       = scl_s & ~scl_d & ~csn_s;
   assign is_tag_bit = mode_3w & (bit_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_d <= 1'b0;
      else        scl_d <= scl_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
         tag_q   <= TAG_CMD;
      end else if (csn_s) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (rise) begin
         if (is_tag_bit) tag_q <= sda_s;
         else            shreg <= {shreg[DATA_W-2:0], sda_s};
         bit_cnt <= (bit_cnt == last_idx) ? '0 : bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte    <= '0;
         rx_is_data <= TAG_CMD;
         rx_valid   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (rise && !csn_s && bit_cnt == last_idx) begin
            rx_byte    <= {shreg[DATA_W-2:0], sda_s};
            rx_is_data <= mode_3w ? tag_q : dc_s;
            rx_valid   <= 1'b1;
         end
      end
   end

   assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_only_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !$past(csn_s));

   assert_clear_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> (bit_cnt == '0));

   assert_count_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= last_idx);

   assert_tag_from_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !mode_3w) |-> (rx_is_data == $past(dc_s)));
endmodule

// File: rtl/disp_serial_rx.sv
module disp_serial_rx #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_3w,
   input  logic              ser_clk,
   input  logic              ser_sda,
   input  logic              ser_csn,
   input  logic              ser_dc,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_is_data,
   output logic              rx_valid
);
   localparam int unsigned NPINS = 4;
   localparam logic [NPINS-1:0] PIN_RST = 4'b0100;

   logic [NPINS-1:0] pins_async;
   logic [NPINS-1:0] pins_sync;

   assign pins_async = {ser_dc, ser_csn, ser_sda, ser_clk};

   srx_sync_bank #(
      .WIDTH   (NPINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_async),
      .q_sync  (pins_sync)
   );

   srx_framer #(
      .DATA_W (DATA_W)
   ) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_3w    (mode_3w),
      .scl_s      (pins_sync[0]),
      .sda_s      (pins_sync[1]),
      .csn_s      (pins_sync[2]),
      .dc_s       (pins_sync[3]),
      .rx_byte    (rx_byte),
      .rx_is_data (rx_is_data),
      .rx_valid   (rx_valid)
   );
endmodule

// File: tb/tb_disp_serial_rx.sv
`timescale 1ns/1ps
module tb_disp_serial_rx;
   localparam time HALF = 20ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_3w = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_sda = 1'b0;
   logic ser_csn = 1'b1;
   logic ser_dc  = 1'b0;
   logic [7:0] rx_byte;
   logic rx_is_data;
   logic rx_valid;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   logic prev_valid = 1'b0;
   logic [8:0] exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   disp_serial_rx dut (
      .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w),
      .ser_clk(ser_clk), .ser_sda(ser_sda), .ser_csn(ser_csn), .ser_dc(ser_dc),
      .rx_byte(rx_byte), .rx_is_data(rx_is_data), .rx_valid(rx_valid)
   );

   task automatic clk_bit(input logic b);
      ser_sda = b;
      #HALF ser_clk = 1'b1;
      #HALF ser_clk = 1'b0;
   endtask

   task automatic select();
      ser_csn = 1'b0;
      #(2*HALF);
   endtask

   task automatic release_sel();
      #(2*HALF) ser_csn = 1'b1;
      #(3*HALF);
   endtask

   // one frame inside an open select window; expectation pushed before sending
   task automatic frame(input logic [7:0] b, input logic is_data, input string tag);
      exp_q.push_back({is_data, b});
      tag_q.push_back(tag);
      if (mode_3w) clk_bit(is_data);
      ser_dc = ~is_data;
      for (int i = 7; i >= 0; i--) begin
         if (i == 0 && !mode_3w) ser_dc = is_data;
         clk_bit(b[i]);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         tests++;
         if (prev_valid) begin
            fails++;
            $display("FAIL R7 strobe width: actual 2+ cycles expected 1");
         end
         tests++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R6 unexpected strobe: actual %h/%b expected none", rx_byte, rx_is_data);
         end else begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({rx_is_data, rx_byte} !== e) begin
               fails++;
               $display("FAIL %s: actual %b/%h expected %b/%h", t, rx_is_data, rx_byte, e[8], e[7:0]);
            end
         end
      end
      prev_valid = rx_valid;
   end

   initial begin
      #(200000 * 5ns);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #33ns rst_n = 1'b1;
      @(negedge clk);
      tests++;
      if (rx_valid !== 1'b0 || rx_byte !== 8'h00 || rx_is_data !== 1'b0) begin
         fails++;
         $display("FAIL R1: actual %b/%h/%b expected 0/00/0", rx_valid, rx_byte, rx_is_data);
      end
      #(2*HALF);

      // 4-wire framing
      mode_3w = 1'b0;
      select();
      frame(8'hA5, 1'b0, "R2 4w command A5");
      release_sel();
      select();
      frame(8'h3C, 1'b1, "R3 4w data with late DC");
      release_sel();
      select();
      frame(8'h01, 1'b1, "R8 4w burst 1");
      frame(8'h80, 1'b0, "R8 4w burst 2");
      frame(8'hFF, 1'b1, "R8 4w burst 3");
      release_sel();

      // clocks while released are ignored
      repeat (3) clk_bit(1'b1);
      #(2*HALF);
      select();
      frame(8'h5A, 1'b1, "R5 alignment after idle clocks");
      release_sel();

      // partial frame discarded
      select();
      for (int i = 0; i < 5; i++) clk_bit(1'b1);
      release_sel();
      select();
      frame(8'h12, 1'b0, "R6 4w frame after abort");
      release_sel();

      // 3-wire framing
      mode_3w = 1'b1;
      #(2*HALF);
      select();
      frame(8'hC3, 1'b1, "R4 3w data C3");
      release_sel();
      select();
      ser_dc = 1'b1;
      frame(8'h7E, 1'b0, "R4 3w command with DC pin high");
      release_sel();
      select();
      frame(8'h00, 1'b1, "R8 3w burst 1");
      frame(8'hAA, 1'b0, "R8 3w burst 2");
      release_sel();
      select();
      for (int i = 0; i < 8; i++) clk_bit(1'b0);
      release_sel();
      select();
      frame(8'h96, 1'b1, "R6 3w frame after 8-bit abort");
      release_sel();

      #(4*HALF);
      tests++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R7 missing strobes: actual %0d pending expected 0", exp_q.size());
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule